// File: doc/BRIEF.md
# Clock Rate Meter

The block estimates the frequency of a clock under test by counting its rising edges inside a window of known length. The window is timed on a reference clock: a gate timer counts down a programmed number of reference ticks, where one tick is a fixed number of reference cycles. The count is kept in the clock-under-test domain. It crosses back to the reference domain as a Gray code, so the value can be read while it is still moving.

Two ways of use are offered. The first is a register-style pair: a control word written by the caller and a status word that is always visible. The second is a built-in sequencer. It performs a short run and then a long run over that same pair. It reports the long count and a rate in hertz, derived with fixed offset terms. It flags the clock as stopped when the two runs return the same raw count. This check is needed because the edge counter can only clear itself on an edge of the clock under test.

Top module: `clkrate_meter`

## Requirements
- R1: After reset the status word is all zero, `seq_busy` is low and `res_valid` is low.
- R2: A control write with bit TICK_W (start) set and tick count T in bits TICK_W-1:0 opens the gate for T ticks of REF_DIV reference cycles each. The done flag (status bit CNT_W) then rises exactly T*REF_DIV+SETTLE reference cycles after the write edge. While done stays high, the count field does not change.
- R3: A control write with the start bit clear, including an all-zero word, clears the done flag and ends any window in progress. Done then stays low and the count stays frozen until the next start.
- R4: The count field (status bits CNT_W-1:0) equals the number of rising edges of the clock under test inside the window, to within 3.
- R5: The count saturates at 2^CNT_W-1 and does not wrap.
- R6: When the clock under test is not running, a complete run leaves the count at its previous value.
- R7: On a `meas_go` pulse, the sequencer runs SHORT_TICKS and then LONG_TICKS. For each run it writes a stop word, waits for done low, writes a start word, waits for done high, then writes zero. `seq_busy` is high throughout, and `res_valid` is a one-cycle pulse at the end.
- R8: If the two runs return the same count, `res_off` is 1 and `res_rate` is 0. Otherwise `res_off` is 0.
- R9: When the clock is running, `res_rate` = ((N*10+15)*REF_HZ)/(LONG_TICKS*10+35), with N the long count (also given on `res_count`), rounded down.
- R10: External control writes are ignored while `seq_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| tst_clk | input | 1 | Clock under test |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | TICK_W+1 | Control word: start bit at TICK_W, tick count below |
| stat_word | output | CNT_W+1 | Status: done at CNT_W, edge count below |
| meas_go | input | 1 | Starts a two-pass sequenced measurement |
| seq_busy | output | 1 | Sequencer owns the control path |
| res_valid | output | 1 | One-cycle result strobe |
| res_off | output | 1 | Clock under test judged stopped |
| res_count | output | CNT_W | Raw count of the long run |
| res_rate | output | RATE_W | Computed rate in hertz |

## Verification
The stopped-clock situation is the hardest to reach. It needs an earlier count left in the counter, then a clock that stops between runs, so that both passes read back that old value. The bench first runs a measurement with the clock running. It then halts its generated test clock. It makes a manual run to show the stale count survives, and finally issues a sequenced measurement that must come back flagged as stopped. Saturation is reached on a second, narrow-counter instance, and the ignored-write rule is exercised by hammering stop words during a sequenced run that must still finish.

// File: rtl/clkrate_pkg.sv
`timescale 1ns/1ps
package clkrate_pkg;
   typedef enum logic [3:0] {
      SQ_IDLE, SQ_STOP, SQ_WCLR, SQ_START, SQ_WDONE,
      SQ_ZERO, SQ_CMP, SQ_DIV, SQ_OUT
   } seq_state_t;

   typedef enum logic {PASS_SHORT, PASS_LONG} pass_t;
endpackage

// File: rtl/clkrate_gate_timer.sv
`timescale 1ns/1ps
module clkrate_gate_timer #(
   parameter int TICK_W  = 20,
   parameter int REF_DIV = 4,
   parameter int SETTLE  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TICK_W:0]   wr_data,
   output logic              gate,
   output logic              done
);
   localparam int DIV_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
   localparam int SET_W = $clog2(SETTLE + 1);
   localparam logic [SET_W-1:0] SET_LOAD = SET_W'(SETTLE);

   logic [TICK_W-1:0] remain;
   logic              running;
   logic [SET_W-1:0]  settle;
   logic              tick;
   logic              zero_req;

   generate
      if (REF_DIV == 1) begin : g_nodiv
         assign tick = running;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (wr_en || !running)
               div_q <= '0;
            else if (div_q == DIV_W'(REF_DIV - 1))
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
         assign tick = running && (div_q == DIV_W'(REF_DIV - 1));
      end
   endgenerate

   assign zero_req = (wr_data[TICK_W-1:0] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain  <= '0;
         running <= 1'b0;
         settle  <= '0;
         done    <= 1'b0;
      end else if (wr_en) begin
         remain <= wr_data[TICK_W-1:0];
         done   <= 1'b0;
         if (wr_data[TICK_W]) begin
            running <= !zero_req;
            settle  <= zero_req ? SET_LOAD : '0;
         end else begin
            running <= 1'b0;
            settle  <= '0;
         end
      end else begin
         if (tick) begin
            remain <= remain - 1'b1;
            if (remain == TICK_W'(1)) begin
               running <= 1'b0;
               settle  <= SET_LOAD;
            end
         end
         if (settle != '0) begin
            settle <= settle - 1'b1;
            if (settle == SET_W'(1))
               done <= 1'b1;
         end
      end
   end

   assign gate = running;
endmodule

// File: rtl/clkrate_edge_counter.sv
`timescale 1ns/1ps
module clkrate_edge_counter #(
   parameter int CNT_W       = 25,
   parameter int SYNC_STAGES = 2
) (
   input  logic             tst_clk,
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             gate_ref,
   output logic [CNT_W-1:0] count_ref
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // clock-under-test domain
   logic [SYNC_STAGES-1:0] gate_sync;
   logic                   gate_now;
   logic                   gate_prev;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       cnt_d;
   logic [CNT_W-1:0]       gray_q;

   assign gate_now = gate_sync[SYNC_STAGES-1];

   always_comb begin
      cnt_d = cnt_q;
      if (gate_now && !gate_prev)
         cnt_d = CNT_W'(1);
      else if (gate_now && (cnt_q != CNT_MAX))
         cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge tst_clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_sync <= '0;
         gate_prev <= 1'b0;
         cnt_q     <= '0;
         gray_q    <= '0;
      end else begin
         gate_sync <= {gate_sync[SYNC_STAGES-2:0], gate_ref};
         gate_prev <= gate_now;
         cnt_q     <= cnt_d;
         gray_q    <= cnt_d ^ (cnt_d >> 1);
      end
   end

   // reference domain
   logic [CNT_W-1:0] gray_sync [SYNC_STAGES];
   logic [CNT_W-1:0] bin_c;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge ref_clk or negedge rst_n) begin
            if (!rst_n)
               gray_sync[s] <= '0;
            else if (s == 0)
               gray_sync[s] <= gray_q;
            else
               gray_sync[s] <= gray_sync[(s == 0) ? 0 : s-1];
         end
      end
      for (genvar b = 0; b < CNT_W; b++) begin : g_bin
         assign bin_c[b] = ^gray_sync[SYNC_STAGES-1][CNT_W-1:b];
      end
   endgenerate

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)
         count_ref <= '0;
      else
         count_ref <= bin_c;
   end
endmodule

// File: rtl/clkrate_divider.sv
`timescale 1ns/1ps
module clkrate_divider #(
   parameter int NUM_W = 52,
   parameter int DEN_W = 25,
   parameter int OUT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [OUT_W-1:0] quo
);
   localparam int STEP_W = $clog2(NUM_W + 1);

   logic [NUM_W-1:0]  q;
   logic [DEN_W-1:0]  r;
   logic [STEP_W-1:0] left;
   logic [DEN_W:0]    trial;
   logic [DEN_W:0]    diff;
   logic              fit;

   assign trial = {r, q[NUM_W-1]};
   assign fit   = (trial >= {1'b0, den});
   assign diff  = trial - {1'b0, den};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= '0;
         r    <= '0;
         left <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            q    <= num;
            r    <= '0;
            left <= STEP_W'(NUM_W);
         end else if (left != '0) begin
            q    <= {q[NUM_W-2:0], fit};
            r    <= fit ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            left <= left - 1'b1;
            if (left == STEP_W'(1))
               done <= 1'b1;
         end
      end
   end

   assign quo = q[OUT_W-1:0];
endmodule

// File: rtl/clkrate_sequencer.sv
`timescale 1ns/1ps
module clkrate_sequencer
   import clkrate_pkg::*;
#(
   parameter int          TICK_W      = 20,
   parameter int          CNT_W       = 25,
   parameter int          RATE_W      = 32,
   parameter int unsigned SHORT_TICKS = 32'h1000,
   parameter int unsigned LONG_TICKS  = 32'h10000,
   parameter int unsigned REF_HZ      = 4800000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              done_bit,
   input  logic [CNT_W-1:0]  count,
   output logic              bus_we,
   output logic [TICK_W:0]   bus_wdata,
   output logic              busy,
   output logic              res_valid,
   output logic              res_off,
   output logic [CNT_W-1:0]  res_count,
   output logic [RATE_W-1:0] res_rate
);
   localparam int HZ_W  = $clog2(REF_HZ + 1);
   localparam int NUM_W = CNT_W + 4 + HZ_W;
   localparam int DEN_W = TICK_W + 5;
   localparam logic [DEN_W-1:0] DEN = DEN_W'(LONG_TICKS * 10 + 35);

   seq_state_t        st;
   pass_t             pass;
   logic [CNT_W-1:0]  cnt_short;
   logic [CNT_W-1:0]  cnt_long;
   logic [TICK_W-1:0] cur_ticks;
   logic [NUM_W-1:0]  num_c;
   logic              div_start;
   logic              div_done;
   logic [RATE_W-1:0] div_quo;

   generate
      if (RATE_W > NUM_W) begin : g_bad_rate
         $error("RATE_W wider than the rate numerator");
      end
   endgenerate

   assign cur_ticks = (pass == PASS_LONG) ? TICK_W'(LONG_TICKS) : TICK_W'(SHORT_TICKS);
   assign busy      = (st != SQ_IDLE);
   assign num_c     = (NUM_W'(cnt_long) * NUM_W'(10) + NUM_W'(15)) * NUM_W'(REF_HZ);
   assign div_start = (st == SQ_CMP) && (cnt_short != cnt_long);

   always_comb begin
      bus_we    = 1'b0;
      bus_wdata = '0;
      case (st)
         SQ_STOP: begin
            bus_we    = 1'b1;
            bus_wdata = {1'b0, cur_ticks};
         end
         SQ_START: begin
            bus_we    = 1'b1;
            bus_wdata = {1'b1, cur_ticks};
         end
         SQ_ZERO: begin
            bus_we    = 1'b1;
            bus_wdata = '0;
         end
         default: ;
      endcase
   end

   clkrate_divider #(
      .NUM_W(NUM_W),
      .DEN_W(DEN_W),
      .OUT_W(RATE_W)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .num   (num_c),
      .den   (DEN),
      .done  (div_done),
      .quo   (div_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         pass      <= PASS_SHORT;
         cnt_short <= '0;
         cnt_long  <= '0;
         res_valid <= 1'b0;
         res_off   <= 1'b0;
         res_count <= '0;
         res_rate  <= '0;
      end else begin
         res_valid <= 1'b0;
         case (st)
            SQ_IDLE: if (go) begin
               pass <= PASS_SHORT;
               st   <= SQ_STOP;
            end
            SQ_STOP:  st <= SQ_WCLR;
            SQ_WCLR:  if (!done_bit) st <= SQ_START;
            SQ_START: st <= SQ_WDONE;
            SQ_WDONE: if (done_bit) begin
               if (pass == PASS_SHORT) cnt_short <= count;
               else                    cnt_long  <= count;
               st <= SQ_ZERO;
            end
            SQ_ZERO: begin
               if (pass == PASS_SHORT) begin
                  pass <= PASS_LONG;
                  st   <= SQ_STOP;
               end else begin
                  st <= SQ_CMP;
               end
            end
            SQ_CMP: begin
               if (cnt_short == cnt_long) begin
                  res_off   <= 1'b1;
                  res_rate  <= '0;
                  res_count <= cnt_long;
                  res_valid <= 1'b1;
                  st        <= SQ_OUT;
               end else begin
                  st <= SQ_DIV;
               end
            end
            SQ_DIV: if (div_done) begin
               res_off   <= 1'b0;
               res_rate  <= div_quo;
               res_count <= cnt_long;
               res_valid <= 1'b1;
               st        <= SQ_OUT;
            end
            SQ_OUT:  st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/clkrate_meter.sv
`timescale 1ns/1ps
module clkrate_meter #(
   parameter int          TICK_W      = 20,
   parameter int          CNT_W       = 25,
   parameter int          REF_DIV     = 4,
   parameter int          SETTLE      = 16,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned SHORT_TICKS = 32'h1000,
   parameter int unsigned LONG_TICKS  = 32'h10000,
   parameter int unsigned REF_HZ      = 4800000,
   parameter int          RATE_W      = 32
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              tst_clk,
   input  logic              ctl_we,
   input  logic [TICK_W:0]   ctl_wdata,
   output logic [CNT_W:0]    stat_word,
   input  logic              meas_go,
   output logic              seq_busy,
   output logic              res_valid,
   output logic              res_off,
   output logic [CNT_W-1:0]  res_count,
   output logic [RATE_W-1:0] res_rate
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (REF_DIV < 1) begin : g_bad_div
         $error("REF_DIV must be at least 1");
      end
      if (SETTLE < 1) begin : g_bad_settle
         $error("SETTLE must be at least 1");
      end
      if (CNT_W < 4 || TICK_W < 2) begin : g_bad_width
         $error("counter or tick field too narrow");
      end
      if (SHORT_TICKS == 0 || SHORT_TICKS >= LONG_TICKS) begin : g_bad_pass
         $error("short run must be non-empty and shorter than the long run");
      end
      if (longint'(LONG_TICKS) >= (longint'(1) << TICK_W)) begin : g_bad_long
         $error("LONG_TICKS does not fit the tick field");
      end
   endgenerate

   logic              bus_we;
   logic [TICK_W:0]   bus_wdata;
   logic              seq_we;
   logic [TICK_W:0]   seq_wdata;
   logic              gate;
   logic              done;
   logic [CNT_W-1:0]  count;

   assign bus_we    = seq_busy ? seq_we    : ctl_we;
   assign bus_wdata = seq_busy ? seq_wdata : ctl_wdata;
   assign stat_word = {done, count};

   clkrate_gate_timer #(
      .TICK_W (TICK_W),
      .REF_DIV(REF_DIV),
      .SETTLE (SETTLE)
   ) u_timer (
      .clk    (ref_clk),
      .rst_n  (rst_n),
      .wr_en  (bus_we),
      .wr_data(bus_wdata),
      .gate   (gate),
      .done   (done)
   );

   clkrate_edge_counter #(
      .CNT_W      (CNT_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_count (
      .tst_clk  (tst_clk),
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .gate_ref (gate),
      .count_ref(count)
   );

   clkrate_sequencer #(
      .TICK_W     (TICK_W),
      .CNT_W      (CNT_W),
      .RATE_W     (RATE_W),
      .SHORT_TICKS(SHORT_TICKS),
      .LONG_TICKS (LONG_TICKS),
      .REF_HZ     (REF_HZ)
   ) u_seq (
      .clk      (ref_clk),
      .rst_n    (rst_n),
      .go       (meas_go),
      .done_bit (done),
      .count    (count),
      .bus_we   (seq_we),
      .bus_wdata(seq_wdata),
      .busy     (seq_busy),
      .res_valid(res_valid),
      .res_off  (res_off),
      .res_count(res_count),
      .res_rate (res_rate)
   );
endmodule

module clkrate_meter_chk #(
   parameter int TICK_W = 20,
   parameter int CNT_W  = 25,
   parameter int RATE_W = 32
) (
   input logic              ref_clk,
   input logic              rst_n,
   input logic [CNT_W:0]    stat_word,
   input logic              bus_we,
   input logic              start_wr,
   input logic              seq_busy,
   input logic              res_valid,
   input logic              res_off,
   input logic [RATE_W-1:0] res_rate
);
   AST_WRITE_CLEARS_DONE: assert property (@(posedge ref_clk) disable iff (!rst_n)
      bus_we |=> !stat_word[CNT_W]); // R3

   AST_DONE_FREEZES_COUNT: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (stat_word[CNT_W] && $past(stat_word[CNT_W])) |-> $stable(stat_word[CNT_W-1:0])); // R2

   AST_START_AFTER_CLEAR: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (seq_busy && bus_we && start_wr) |-> !stat_word[CNT_W]); // R7

   AST_VALID_ONE_CYCLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
      res_valid |=> !res_valid); // R7

   AST_VALID_WHILE_BUSY: assert property (@(posedge ref_clk) disable iff (!rst_n)
      res_valid |-> seq_busy); // R7

   AST_OFF_MEANS_ZERO: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (res_valid && res_off) |-> (res_rate == '0)); // R8
endmodule

bind clkrate_meter clkrate_meter_chk #(
   .TICK_W(TICK_W),
   .CNT_W (CNT_W),
   .RATE_W(RATE_W)
) u_chk (
   .ref_clk  (ref_clk),
   .rst_n    (rst_n),
   .stat_word(stat_word),
   .bus_we   (bus_we),
   .start_wr (bus_wdata[TICK_W]),
   .seq_busy (seq_busy),
   .res_valid(res_valid),
   .res_off  (res_off),
   .res_rate (res_rate)
);

// File: tb/sim_clkrate_meter.sv
`timescale 1ns/1ps
module sim_clkrate_meter;
   localparam int TICK_W  = 20;
   localparam int CNT_W   = 25;
   localparam int REF_DIV = 4;
   localparam int SETTLE  = 24;
   localparam int SHORT   = 16;
   localparam int LONG    = 128;
   localparam int RATE_W  = 32;
   localparam longint unsigned REF_HZ = 4800000;
   localparam longint LONG_WIN_PS = longint'(LONG) * REF_DIV * 10000;

   localparam int NVEC = 5;
   localparam int unsigned VEC_PS [NVEC] = '{7000, 10000, 13000, 23000, 37000};

   logic ref_clk = 1'b0;
   logic tst_clk = 1'b0;
   logic rst_n   = 1'b0;
   bit   tst_on  = 1'b1;
   realtime tst_half = 5.0;

   always #5 ref_clk = ~ref_clk;
   always begin
      if (tst_on) begin
         #(tst_half);
         tst_clk = ~tst_clk;
      end else begin
         #1;
      end
   end

   logic              ctl_we = 1'b0;
   logic [TICK_W:0]   ctl_wdata = '0;
   logic [CNT_W:0]    stat_word;
   logic              meas_go = 1'b0;
   logic              seq_busy, res_valid, res_off;
   logic [CNT_W-1:0]  res_count;
   logic [RATE_W-1:0] res_rate;

   clkrate_meter #(
      .TICK_W(TICK_W), .CNT_W(CNT_W), .REF_DIV(REF_DIV), .SETTLE(SETTLE),
      .SYNC_STAGES(2), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG),
      .REF_HZ(32'(REF_HZ)), .RATE_W(RATE_W)
   ) u0 (
      .ref_clk(ref_clk), .rst_n(rst_n), .tst_clk(tst_clk),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .stat_word(stat_word),
      .meas_go(meas_go), .seq_busy(seq_busy), .res_valid(res_valid),
      .res_off(res_off), .res_count(res_count), .res_rate(res_rate)
   );

   // narrow-counter instance for saturation
   logic       ctl1_we = 1'b0;
   logic [8:0] ctl1_wdata = '0;
   logic [6:0] stat1;
   logic       busy1, valid1, off1;
   logic [5:0] count1;
   logic [31:0] rate1;

   clkrate_meter #(
      .TICK_W(8), .CNT_W(6), .REF_DIV(REF_DIV), .SETTLE(SETTLE),
      .SYNC_STAGES(2), .SHORT_TICKS(4), .LONG_TICKS(16),
      .REF_HZ(32'(REF_HZ)), .RATE_W(32)
   ) u1 (
      .ref_clk(ref_clk), .rst_n(rst_n), .tst_clk(tst_clk),
      .ctl_we(ctl1_we), .ctl_wdata(ctl1_wdata), .stat_word(stat1),
      .meas_go(1'b0), .seq_busy(busy1), .res_valid(valid1),
      .res_off(off1), .res_count(count1), .res_rate(rate1)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint unsigned exp_rate(input longint unsigned n);
      return ((n * 10 + 15) * REF_HZ) / (longint'(LONG) * 10 + 35);
   endfunction

   function automatic longint absdiff(input longint a, input longint b);
      return (a > b) ? a - b : b - a;
   endfunction

   task automatic write_ctl(input bit start, input int ticks);
      @(negedge ref_clk);
      ctl_we    = 1'b1;
      ctl_wdata = {start, TICK_W'(ticks)};
      @(posedge ref_clk);
      @(negedge ref_clk);
      ctl_we    = 1'b0;
   endtask

   task automatic manual_run(input int ticks, output int cyc);
      write_ctl(1'b1, ticks);
      cyc = 0;
      while (!stat_word[CNT_W] && cyc < 20000) begin
         @(posedge ref_clk);
         @(negedge ref_clk);
         cyc++;
      end
   endtask

   task automatic run_seq(output longint unsigned cnt, output longint unsigned rate,
                          output bit off, output int cyc, output bit busy_seen,
                          output bit valid_after);
      @(negedge ref_clk);
      meas_go = 1'b1;
      @(negedge ref_clk);
      meas_go   = 1'b0;
      busy_seen = seq_busy;
      cyc = 1;
      while (!res_valid && cyc < 20000) begin
         @(negedge ref_clk);
         cyc++;
      end
      cnt  = res_count;
      rate = res_rate;
      off  = res_off;
      @(negedge ref_clk);
      valid_after = res_valid;
   endtask

   initial begin
      repeat (150000) @(posedge ref_clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      longint unsigned cnt, rate, c0, c1;
      bit off, bs, va;
      int cyc;

      // R1 reset state
      repeat (3) @(negedge ref_clk);
      check(stat_word == '0, "R1 status in reset", stat_word, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge ref_clk);
      check(stat_word == '0, "R1 status after reset", stat_word, 0);
      check(!seq_busy && !res_valid, "R1 busy/valid idle", {seq_busy, res_valid}, 0);

      // R2 done latency and R4 accuracy, 10 ns test clock
      tst_half = 5.0;
      repeat (10) @(negedge ref_clk);
      manual_run(20, cyc);
      check(cyc == 20 * REF_DIV + SETTLE, "R2 done latency", cyc, 20 * REF_DIV + SETTLE);
      check(absdiff(longint'(stat_word[CNT_W-1:0]), 80) <= 3, "R4 manual count",
            stat_word[CNT_W-1:0], 80);
      repeat (5) @(negedge ref_clk);
      check(stat_word[CNT_W] == 1'b1, "R2 done holds", stat_word[CNT_W], 1);
      write_ctl(1'b0, 0);
      check(stat_word[CNT_W] == 1'b0, "R3 zero write clears done", stat_word[CNT_W], 0);

      // vector table: sequenced runs at several test periods
      for (int v = 0; v < NVEC; v++) begin
         longint expc;
         tst_half = real'(VEC_PS[v]) / 2000.0;
         repeat (10) @(negedge ref_clk);
         expc = LONG_WIN_PS / longint'(VEC_PS[v]);
         run_seq(cnt, rate, off, cyc, bs, va);
         check(absdiff(longint'(cnt), expc) <= 3, "R4 long count", cnt, expc);
         check(off == 1'b0, "R8 running clock not off", off, 0);
         check(rate == exp_rate(cnt), "R9 rate formula", rate, exp_rate(cnt));
         check(bs && !va, "R7 busy seen and single valid", {bs, va}, 2);
         check(cyc >= (SHORT + LONG) * REF_DIV + 2 * SETTLE, "R7 both passes run",
               cyc, (SHORT + LONG) * REF_DIV + 2 * SETTLE);
      end

      // R3 abort a run with a stop write
      tst_half = 5.0;
      repeat (10) @(negedge ref_clk);
      write_ctl(1'b1, 100);
      repeat (40) @(negedge ref_clk);
      write_ctl(1'b0, 100);
      repeat (600) @(negedge ref_clk);
      check(stat_word[CNT_W] == 1'b0, "R3 aborted run never done", stat_word[CNT_W], 0);
      c1 = stat_word[CNT_W-1:0];
      repeat (50) @(negedge ref_clk);
      check(stat_word[CNT_W-1:0] == c1, "R3 count frozen after stop", stat_word[CNT_W-1:0], c1);

      // R6 stopped test clock keeps stale count
      manual_run(20, cyc);
      write_ctl(1'b0, 0);
      tst_on = 1'b0;
      repeat (20) @(negedge ref_clk);
      c0 = stat_word[CNT_W-1:0];
      manual_run(20, cyc);
      check(stat_word[CNT_W-1:0] == c0, "R6 count held with clock stopped",
            stat_word[CNT_W-1:0], c0);
      write_ctl(1'b0, 0);

      // R8 sequenced measurement of a stopped clock
      run_seq(cnt, rate, off, cyc, bs, va);
      check(off == 1'b1, "R8 stopped clock flagged", off, 1);
      check(rate == 0, "R8 stopped clock rate zero", rate, 0);
      check(cnt == c0, "R8 stale count reported", cnt, c0);

      // R10 external writes ignored while sequencer busy
      tst_on = 1'b1;
      repeat (10) @(negedge ref_clk);
      @(negedge ref_clk);
      meas_go = 1'b1;
      @(negedge ref_clk);
      meas_go   = 1'b0;
      ctl_wdata = '0;
      cyc = 1;
      for (int k = 0; k < 300; k++) begin
         ctl_we = 1'b1;
         @(negedge ref_clk);
         cyc++;
      end
      ctl_we = 1'b0;
      while (!res_valid && cyc < 20000) begin
         @(negedge ref_clk);
         cyc++;
      end
      check(res_valid == 1'b1, "R10 result despite external writes", res_valid, 1);
      check(absdiff(longint'(res_count), LONG_WIN_PS / 10000) <= 3, "R10 count unaffected",
            res_count, LONG_WIN_PS / 10000);

      // R5 saturation on narrow instance
      tst_half = 3.5;
      repeat (10) @(negedge ref_clk);
      @(negedge ref_clk);
      ctl1_we    = 1'b1;
      ctl1_wdata = {1'b1, 8'd64};
      @(negedge ref_clk);
      ctl1_we = 1'b0;
      cyc = 0;
      while (!stat1[6] && cyc < 5000) begin
         @(negedge ref_clk);
         cyc++;
      end
      check(stat1[5:0] == 6'd63, "R5 count saturates", stat1[5:0], 63);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule